// File: doc/BRIEF.md
# Per-Channel Static-Sample Auto-Mute

This block sits beside the left and right sample streams that feed a stereo DAC. It watches every accepted sample and, while its enable is on, raises a mute request for a channel once that channel has delivered a long unbroken run of identical static samples. A static sample is either all zeros or all ones (the two's-complement value minus one). A single non-static sample drops that channel's mute straight away. Each channel is tracked on its own, with its own run counter, mute request and mute-control pin. Downstream volume or ramp logic is expected to consume the mute request; this block does no ramping itself.

Samples arrive on a valid/ready interface carrying one left word and one right word per beat. The block never applies back-pressure once reset is over: ready rises on the first edge after reset is released and then stays high, so a beat is accepted on every cycle where valid is high. While ready is low, valid is ignored and nothing is counted. The enable lives in a one-bit register that comes out of reset set, and software changes it with a write strobe.

Top module: `auto_mute`

## Requirements
- R1: During and right after reset both mute outputs are 0, both mute-control pins are at their inactive level (1, since the pins are active-low), and the enable register holds 1, so auto-mute works without any write.
- R2: A sample counts as static only when all SAMPLE_W bits are 0 or all are 1; any other word, such as 24'h000001 or 24'h800000, is non-static.
- R3: A channel's mute output goes to 1 on the clock edge that accepts its MUTE_RUN-th (default 8192) consecutive static sample of one value, and stays 0 after only MUTE_RUN-1 of them.
- R4: A static sample whose value differs from the current run (0 after -1, or -1 after 0) starts a new run at a count of one, and it does not release an existing mute.
- R5: An accepted non-static sample clears that channel's count and mute output on the edge that accepts it.
- R6: The left channel (bit 0 of each two-bit output) and the right channel (bit 1) count and mute independently.
- R7: The run count and the mute output change only on a beat where valid and ready are both high; idle cycles neither advance nor break a run.
- R8: The run count saturates at MUTE_RUN; further static samples keep the mute set and never wrap.
- R9: Writing the enable as 0 clears both counts and both mutes on the same edge as the write; while disabled nothing counts; after re-enabling, a full new run of MUTE_RUN samples is needed.
- R10: Each mute-control pin is driven low exactly while its channel's mute output is 1.
- R11: Ready goes to 1 one edge after reset is released and stays 1 for as long as reset stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | A left/right sample pair is present |
| smp_ready_o | output | 1 | Block accepts the pair; high every cycle after reset |
| smp_left_i | input | SAMPLE_W | Signed left sample word |
| smp_right_i | input | SAMPLE_W | Signed right sample word |
| cfg_we_i | input | 1 | Write strobe for the enable register |
| cfg_en_i | input | 1 | Value written to the enable register |
| mute_o | output | 2 | Mute request, bit 0 left, bit 1 right |
| mute_ctl_o | output | 2 | Active-low mute-control pins, bit 0 left, bit 1 right |

## Verification
Every result is registered once. A mute that sets on the MUTE_RUN-th sample, a release caused by a non-static sample, and a clear caused by an enable write all show on the outputs one clock edge after the stimulus is presented. Ready appears one edge after reset is released. The bench changes its inputs on the falling edge and steps a reference model for the next rising edge. It then reads the outputs on the following falling edge, half a period after the edge that updated them, so every comparison sees exactly one register stage of delay. The directed runs stop at MUTE_RUN-1 and at MUTE_RUN so the edge of the threshold is checked in its exact cycle.

// File: rtl/amute_pkg.sv
package amute_pkg;
  // Class of a sample word and of the run being counted.
  typedef enum logic [1:0] {
    RUN_NONE = 2'd0,
    RUN_ZERO = 2'd1,
    RUN_ONES = 2'd2
  } run_kind_e;
endpackage

// File: rtl/amute_classify.sv
module amute_classify
  import amute_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] smp_i,
  output run_kind_e           kind_o
);
  always_comb begin
    if (smp_i == '0)     kind_o = RUN_ZERO;
    else if (&smp_i)     kind_o = RUN_ONES;
    else                 kind_o = RUN_NONE;
  end
endmodule

// File: rtl/amute_enable.sv
module amute_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  logic wdata_i,
  output logic en_next_o
);
  logic en_q;

  // Value the register takes at the coming edge; channels act on it directly
  assign en_next_o = we_i ? wdata_i : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_next_o;
  end
endmodule

// File: rtl/amute_chan.sv
module amute_chan
  import amute_pkg::*;
#(
  parameter int MUTE_RUN = 8192,
  parameter int CNT_W    = $clog2(MUTE_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             take_i,
  input  run_kind_e        kind_i,
  output logic             mute_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] RUN_C = CNT_W'(MUTE_RUN);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  run_kind_e        kind_q, kind_d;
  logic             mute_q, mute_d;

  always_comb begin
    cnt_d  = cnt_q;
    kind_d = kind_q;
    mute_d = mute_q;
    if (!en_i) begin
      cnt_d  = '0;
      kind_d = RUN_NONE;
      mute_d = 1'b0;
    end else if (take_i) begin
      if (kind_i == RUN_NONE) begin
        cnt_d  = '0;
        kind_d = RUN_NONE;
        mute_d = 1'b0;
      end else begin
        if (kind_i == kind_q) begin
          if (cnt_q != RUN_C) cnt_d = cnt_q + ONE_C;
        end else begin
          cnt_d  = ONE_C;
          kind_d = kind_i;
        end
        if (cnt_d == RUN_C) mute_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      kind_q <= RUN_NONE;
      mute_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      mute_q <= mute_d;
    end
  end

  assign mute_o = mute_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/auto_mute.sv
module auto_mute
  import amute_pkg::*;
#(
  parameter int SAMPLE_W       = 24,
  parameter int MUTE_RUN       = 8192,
  parameter bit CTL_ACTIVE_LOW = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid_i,
  output logic                smp_ready_o,
  input  logic [SAMPLE_W-1:0] smp_left_i,
  input  logic [SAMPLE_W-1:0] smp_right_i,
  input  logic                cfg_we_i,
  input  logic                cfg_en_i,
  output logic [1:0]          mute_o,
  output logic [1:0]          mute_ctl_o
);
  localparam int NUM_CH = 2;
  localparam int CNT_W  = $clog2(MUTE_RUN + 1);

  logic                           rdy_q;
  logic                           take_w;
  logic                           en_w;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_w;
  logic [NUM_CH-1:0][CNT_W-1:0]    cnt_w;
  run_kind_e                      kind_w [NUM_CH];

  // Never stalls: ready comes up one edge after reset and stays up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign smp_ready_o = rdy_q;
  assign take_w      = smp_valid_i & rdy_q;

  assign smp_w[0] = smp_left_i;
  assign smp_w[1] = smp_right_i;

  amute_enable u_enable (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_en_i),
    .en_next_o (en_w)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    amute_classify #(.SAMPLE_W(SAMPLE_W)) u_cls (
      .smp_i  (smp_w[ch]),
      .kind_o (kind_w[ch])
    );

    amute_chan #(.MUTE_RUN(MUTE_RUN), .CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_w),
      .take_i (take_w),
      .kind_i (kind_w[ch]),
      .mute_o (mute_o[ch]),
      .cnt_o  (cnt_w[ch])
    );

    if (CTL_ACTIVE_LOW) begin : g_low
      assign mute_ctl_o[ch] = ~mute_o[ch];
    end else begin : g_high
      assign mute_ctl_o[ch] = mute_o[ch];
    end
  end
endmodule

// File: rtl/amute_chk.sv
module amute_chk #(
  parameter int SAMPLE_W = 24,
  parameter int MUTE_RUN = 8192,
  parameter int CNT_W    = 14
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          smp_valid_i,
  input logic                          smp_ready_o,
  input logic [SAMPLE_W-1:0]           smp_left_i,
  input logic [SAMPLE_W-1:0]           smp_right_i,
  input logic                          cfg_we_i,
  input logic                          cfg_en_i,
  input logic [1:0]                    mute_o,
  input logic [1:0][CNT_W-1:0]         cnt_w
);
  logic [SAMPLE_W-1:0] smp_c [2];
  assign smp_c[0] = smp_left_i;
  assign smp_c[1] = smp_right_i;

  function automatic logic quiet(input logic [SAMPLE_W-1:0] s);
    return (s == '0) || (&s);
  endfunction

  // R11: once up, ready never drops outside reset
  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_ready_o) |-> smp_ready_o);

  // R9: a write of 0 leaves both channels unmuted
  assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !cfg_en_i) |=> (mute_o == 2'b00));

  // R7: without an accepted beat or a write the mutes hold
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(smp_valid_i && smp_ready_o) && !cfg_we_i) |=> $stable(mute_o));

  for (genvar c = 0; c < 2; c++) begin : g_ch
    // R5: accepted non-static sample releases that channel
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid_i && smp_ready_o && !quiet(smp_c[c])) |=> !mute_o[c]);

    // R3: mute only rises with a full run counted
    assert_rise_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mute_o[c]) |-> (cnt_w[c] == CNT_W'(MUTE_RUN)));

    // R8: the count never passes the threshold
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_w[c] <= CNT_W'(MUTE_RUN));
  end
endmodule

bind auto_mute amute_chk #(
  .SAMPLE_W (SAMPLE_W),
  .MUTE_RUN (MUTE_RUN),
  .CNT_W    (CNT_W)
) u_amute_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid_i (smp_valid_i),
  .smp_ready_o (smp_ready_o),
  .smp_left_i  (smp_left_i),
  .smp_right_i (smp_right_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_en_i    (cfg_en_i),
  .mute_o      (mute_o),
  .cnt_w       (cnt_w)
);

// File: tb/test_auto_mute.sv
module test_auto_mute;
  localparam int W   = 24;
  localparam int RUN = 8192;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] BUSY = 24'h123456;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_valid_i = 1'b0;
  logic         smp_ready_o;
  logic [W-1:0] smp_left_i = '0;
  logic [W-1:0] smp_right_i = '0;
  logic         cfg_we_i = 1'b0;
  logic         cfg_en_i = 1'b0;
  logic [1:0]   mute_o;
  logic [1:0]   mute_ctl_o;

  int errors = 0;
  int checks = 0;

  // reference model
  int   m_cnt [2];
  int   m_kind [2];
  logic m_mute [2];
  logic m_en;

  always #10 clk = ~clk;

  auto_mute #(.SAMPLE_W(W), .MUTE_RUN(RUN)) i_auto_mute (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid_i (smp_valid_i),
    .smp_ready_o (smp_ready_o),
    .smp_left_i  (smp_left_i),
    .smp_right_i (smp_right_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_en_i    (cfg_en_i),
    .mute_o      (mute_o),
    .mute_ctl_o  (mute_ctl_o)
  );

  function automatic int cls(input logic [W-1:0] s);
    if (s == ZERO) return 1;
    if (s == ONES) return 2;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_ch(input int c, input logic take, input logic [W-1:0] s);
    int k;
    if (!m_en) begin
      m_cnt[c] = 0; m_kind[c] = 0; m_mute[c] = 1'b0;
    end else if (take) begin
      k = cls(s);
      if (k == 0) begin
        m_cnt[c] = 0; m_kind[c] = 0; m_mute[c] = 1'b0;
      end else begin
        if (k == m_kind[c]) begin
          if (m_cnt[c] < RUN) m_cnt[c]++;
        end else begin
          m_cnt[c] = 1; m_kind[c] = k;
        end
        if (m_cnt[c] == RUN) m_mute[c] = 1'b1;
      end
    end
  endtask

  // inputs driven at a falling edge, outputs read at the next falling edge
  task automatic step(input logic v, input logic [W-1:0] l, input logic [W-1:0] r,
                      input logic we, input logic en, input string req);
    logic [1:0] exp;
    smp_valid_i = v; smp_left_i = l; smp_right_i = r;
    cfg_we_i = we; cfg_en_i = en;
    if (we) m_en = en;
    model_ch(0, v, l);
    model_ch(1, v, r);
    @(posedge clk);
    @(negedge clk);
    exp = {m_mute[1], m_mute[0]};
    chk(req, {30'd0, mute_o}, {30'd0, exp});
    chk("R10", {30'd0, mute_ctl_o}, {30'd0, ~exp});
  endtask

  task automatic run(input int n, input logic [W-1:0] l, input logic [W-1:0] r, input string req);
    for (int i = 0; i < n; i++) step(1'b1, l, r, 1'b0, 1'b0, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int mode [2];
    logic [W-1:0] s [2];
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = 0; m_kind[c] = 0; m_mute[c] = 1'b0;
    end
    m_en = 1'b1;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", {30'd0, mute_o}, 32'd0);
    chk("R1", {30'd0, mute_ctl_o}, 32'd3);
    chk("R11", {31'd0, smp_ready_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {31'd0, smp_ready_o}, 32'd1);
    chk("R1", {30'd0, mute_o}, 32'd0);

    // R3 threshold edge on left, right busy (R6)
    run(RUN - 1, ZERO, BUSY, "R3");
    chk("R3", {31'd0, mute_o[0]}, 32'd0);
    step(1'b1, ZERO, BUSY, 1'b0, 1'b0, "R3");
    chk("R3", {31'd0, mute_o[0]}, 32'd1);
    chk("R6", {31'd0, mute_o[1]}, 32'd0);
    chk("R10", {31'd0, mute_ctl_o[0]}, 32'd0);

    // R8 saturation, R4 switching value keeps mute
    run(300, ZERO, BUSY, "R8");
    chk("R8", {31'd0, mute_o[0]}, 32'd1);
    step(1'b1, ONES, BUSY, 1'b0, 1'b0, "R4");
    chk("R4", {31'd0, mute_o[0]}, 32'd1);

    // R5 one non-static sample releases; R2 high-bit-only word is not static
    step(1'b1, 24'h800000, BUSY, 1'b0, 1'b0, "R5");
    chk("R5", {31'd0, mute_o[0]}, 32'd0);
    step(1'b1, 24'h000001, BUSY, 1'b0, 1'b0, "R2");
    chk("R2", {31'd0, mute_o[0]}, 32'd0);

    // R4 change of value restarts the count
    run(5000, ZERO, BUSY, "R4");
    run(RUN - 1, ONES, BUSY, "R4");
    chk("R4", {31'd0, mute_o[0]}, 32'd0);
    step(1'b1, ONES, BUSY, 1'b0, 1'b0, "R4");
    chk("R4", {31'd0, mute_o[0]}, 32'd1);

    // R7 idle cycles neither count nor break a run (right channel)
    for (int i = 0; i < RUN - 1; i++) begin
      step(1'b0, BUSY, BUSY, 1'b0, 1'b0, "R7");
      step(1'b1, ONES, ZERO, 1'b0, 1'b0, "R7");
    end
    step(1'b0, BUSY, BUSY, 1'b0, 1'b0, "R7");
    chk("R7", {31'd0, mute_o[1]}, 32'd0);
    chk("R6", {31'd0, mute_o[0]}, 32'd1);
    step(1'b1, ONES, ZERO, 1'b0, 1'b0, "R7");
    chk("R7", {30'd0, mute_o}, 32'd3);

    // R9 disable clears, no counting while off, full run after re-enable
    step(1'b0, ZERO, ZERO, 1'b1, 1'b0, "R9");
    chk("R9", {30'd0, mute_o}, 32'd0);
    run(RUN + 10, ZERO, ZERO, "R9");
    chk("R9", {30'd0, mute_o}, 32'd0);
    step(1'b0, ZERO, ZERO, 1'b1, 1'b1, "R9");
    run(RUN - 1, ZERO, ZERO, "R9");
    chk("R9", {30'd0, mute_o}, 32'd0);
    step(1'b1, ZERO, ZERO, 1'b0, 1'b0, "R9");
    chk("R9", {30'd0, mute_o}, 32'd3);

    // constrained random: sticky per-channel classes, gaps, rare enable writes
    mode[0] = 1; mode[1] = 2;
    for (int i = 0; i < 30000; i++) begin
      logic v, we, en;
      for (int c = 0; c < 2; c++) begin
        if ($urandom_range(3999) == 0) mode[c] = $urandom_range(2);
        if (mode[c] == 1)      s[c] = ZERO;
        else if (mode[c] == 2) s[c] = ONES;
        else if ($urandom_range(1) == 0) s[c] = ZERO;
        else                   s[c] = W'($urandom);
      end
      v  = ($urandom_range(9) < 8);
      we = ($urandom_range(4999) == 0);
      en = ($urandom_range(3) != 0);
      step(v, s[0], s[1], we, en, "R6");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule